// File: doc/BRIEF.md
# Signed Sequential Multiplier with Merged Add and Shift

This block multiplies two two's complement operands of `W` bits (4 by default) and returns their signed product on `2W` bits. It works one multiplier bit per clock cycle. The multiplier is loaded into the low half of a working register and is used up from its least significant bit as the register moves right. Each cycle adds the multiplicand to the upper half, or adds nothing, and the adder result is stored already moved one place right. This way the add and the shift take a single clock.

The right shift is arithmetic, so the partial product keeps its sign at every step. The multiplier's sign bit has a negative weight. When that bit is set, the final step therefore subtracts the multiplicand instead of adding it.

A caller pulses `start` with both operands valid. It then waits for the one-cycle `done` pulse and reads `product`, which holds its value until the next accepted `start`.

Top module: `signed_addshift_mul`

## Requirements
- R1: With both operands read as two's complement, `product` at `done` equals their signed product as a `2W`-bit two's complement value. This holds for every sign combination, for example 0111×0101 = 00100011, 1101×0101 = 11110001, 0101×1101 = 11110001 and 1011×1101 = 00001111.
- R2: The most negative operand times itself gives the positive value 2^(2W-2). For W=4, 1000×1000 = 01000000 (+64).
- R3: When the multiplier is negative (its top bit is 1), the last step subtracts the multiplicand, so the product is still correct.
- R4: A zero multiplicand or a zero multiplier gives a product of all zeros.
- R5: `start` is sampled at a rising edge while the block is idle. `done` is then high after exactly `W` further rising edges, one step per multiplier bit.
- R6: `done` stays high for exactly one clock cycle. It is low while a multiplication is in progress.
- R7: A `start` that arrives while a multiplication is in progress is ignored. The running result and its timing do not change.
- R8: After `done`, `product` keeps its value until the next `start` is accepted.
- R9: After reset, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication (sampled when idle) |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| product | output | 2W | Signed product, valid from `done` |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The bench runs every pair of 4-bit operands and then seeded random pairs. A design that shifted logically instead of arithmetically would corrupt products with a negative multiplicand. A design that added the multiplicand in the last step instead of subtracting it would be wrong for every negative multiplier. A partial-product register with no guard bit would overflow on 1000×1000 and return a negative value. Separate cases check that a `start` during a run is ignored, and that the latency and the single-cycle `done` are exact. A counter that is off by one would make the latency too short or too long and would leave the product unfinished.

// File: rtl/signed_addshift_mul.sv
module signed_addshift_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic                busy;
  logic [CW-1:0]       cnt;
  logic signed [W:0]   hi;
  logic [W-1:0]        lo;
  logic [W-1:0]        mreg;

  wire               last   = (cnt == CW'(W - 1));
  wire signed [W:0]  mext   = {mreg[W-1], mreg};
  wire signed [W:0]  addend = lo[0] ? (last ? -mext : mext) : '0;
  wire signed [W:0]  sum    = hi + addend;

  assign product = {hi[W-1:0], lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      hi   <= '0;
      lo   <= '0;
      mreg <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          hi   <= '0;
          lo   <= mplier;
          mreg <= mcand;
        end
      end else begin
        // sum stored one place right: add and arithmetic shift in one cycle
        hi  <= {sum[W], sum[W:1]};
        lo  <= {sum[0], lo[W-1:1]};
        cnt <= cnt + CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_run_length_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && !done));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mreg));
  assert_hold_product_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/signed_addshift_mul_test.sv
module signed_addshift_mul_test;
  localparam int W = 4;

  logic           clk = 0;
  logic           rst = 1;
  logic           start = 0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  signed_addshift_mul #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = $signed(a) * $signed(b);
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req, input bit poke_busy);
    int n;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 50) begin
      if (poke_busy && n == 1) begin
        mcand = ~a; mplier = ~b; start = 1;
      end else begin
        start = 0;
      end
      @(negedge clk);
      n++;
    end
    start = 0;
    check(n == W, poke_busy ? "R7 latency" : "R5 latency", 2*W'(n), 2*W'(W));
    check(product == exp, req, product, exp);
    @(negedge clk);
    check(!done, "R6 pulse", {7'd0, done}, '0);
    check(product == exp, "R8 hold", product, exp);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst = 0;
    check(product == '0 && !done, "R9 reset", product, '0);
    run_op(4'b0111, 4'b0101, "R1 pos*pos", 0);
    run_op(4'b1101, 4'b0101, "R1 neg*pos", 0);
    run_op(4'b0101, 4'b1101, "R3 pos*neg", 0);
    run_op(4'b1011, 4'b1101, "R3 neg*neg", 0);
    run_op(4'b1000, 4'b1000, "R2 min*min", 0);
    run_op(4'b0000, 4'b1011, "R4 zero mcand", 0);
    run_op(4'b1001, 4'b0000, "R4 zero mplier", 0);
    run_op(4'b0110, 4'b1010, "R7 start while busy", 1);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_op(W'(i), W'(j), (j >= 8) ? "R3 exhaustive" : "R1 exhaustive", 0);
    for (int k = 0; k < 100; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom); rb = W'($urandom);
      run_op(ra, rb, rb[W-1] ? "R3 random" : "R1 random", (k % 7) == 0);
    end
    repeat (3) @(negedge clk);
    check(!done, "R8 idle no done", {7'd0, done}, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule